// File: doc/BRIEF.md
# Pisano End-Around-Carry Checksum Engine

This block computes a 32-bit signature over a stream of 16-bit words using only addition and XOR. It holds two 16-bit registers that feed each other in a Fibonacci-like pattern, plus a one-bit carry. On each accepted word, one register takes the low half of the sum of both registers and the saved carry. The other register takes the old value of the first register XORed with the word. The carry out of each sum is not wrapped back at once. It is saved and added into the next word's sum, which gives an end-around-carry (ones'-complement style) accumulation.

Words arrive on a valid/ready handshake, one per clock. A synchronous clear loads the starting value. A last-word marker ends the stream. In the cycle after the last word is absorbed, the engine shows both registers as the checksum together with a one-cycle done pulse. It then returns to the starting value on its own, ready for the next stream.

Top module: `eac_pair_checksum`

## Requirements
- R1: After reset, `sum_out` reads 32'h0001_0000 (first register 1, second register 0, hidden carry 0), `sum_valid` is 0 and `in_ready` is 1.
- R2: While `clear` is high, `in_ready` is low, so a word presented in that cycle is not absorbed. On the next cycle `sum_out` reads 32'h0001_0000 and the hidden carry is 0.
- R3: When a word is accepted, the new first register (`sum_out[31:16]`) equals the low 16 bits of (old first register + old second register + saved carry).
- R4: When a word is accepted, the new second register (`sum_out[15:0]`) equals the old first register XOR `in_data`.
- R5: The carry out of a sum (bit 16) is saved and added into the sum of the next accepted word, not into the current one. Starting from the seed, the words FFFF, FFFF, FFFF, 0000 give 32'hFFFE_FFFD.
- R6: In a cycle with no accepted word and no clear, the registers and the carry keep their values.
- R7: `sum_valid` goes high for exactly one cycle, in the cycle after a word marked with `in_last` is accepted. `in_ready` is low in that cycle.
- R8: While `sum_valid` is high, `sum_out` is {first register, second register}, taken after the last word was absorbed. The carry is not folded into it.
- R9: In the cycle after `sum_valid`, the engine is back at the seed state (`sum_out` = 32'h0001_0000, carry 0), even without a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous reload of the seed state; takes priority over a word |
| in_valid | input | 1 | Data word present |
| in_ready | output | 1 | Engine can absorb a word this cycle |
| in_last | input | 1 | Marks the final word of a stream |
| in_data | input | 16 | Data word |
| sum_valid | output | 1 | One-cycle done pulse; checksum valid |
| sum_out | output | 32 | {first register, second register} |

## Verification
The hardest case to reach from the ports is a saved carry that must be consumed by the following word. The carry is not visible at the ports, and it only appears when both registers are large at the same time. The all-0xFFFF stream sets the carry within three words, and a directed fourth word of zero shows whether the carry was added one step late. Random streams with gaps in `in_valid`, clears in the middle of a stream, and clears in the same cycle as the done pulse are checked against a cycle-by-cycle model. They also cover the collisions between clear, the handshake and the automatic reseed.

// File: rtl/eac_pair_pkg.sv
package eac_pair_pkg;

  // Command from the sequencer to the state registers.
  typedef enum logic [1:0] {
    CMD_HOLD   = 2'd0,
    CMD_SEED   = 2'd1,
    CMD_ABSORB = 2'd2
  } eac_cmd_e;

endpackage

// File: rtl/eac_pair_step.sv
// One step of the recurrence: pure combinational arithmetic.
module eac_pair_step #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x_cur,
  input  logic [W-1:0] y_cur,
  input  logic         c_cur,
  input  logic [W-1:0] word,
  output logic [W-1:0] x_nxt,
  output logic [W-1:0] y_nxt,
  output logic         c_nxt
);

  localparam int unsigned SW = W + 1;

  // Plain sum of both registers and the carry saved from the previous step.
  function automatic logic [SW-1:0] pair_sum(input logic [W-1:0] a,
                                             input logic [W-1:0] b,
                                             input logic         cin);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  endfunction

  // The incoming word perturbs the register being replaced.
  function automatic logic [W-1:0] perturb(input logic [W-1:0] a,
                                           input logic [W-1:0] d);
    return a ^ d;
  endfunction

  logic [SW-1:0] total;

  always_comb begin
    total = pair_sum(x_cur, y_cur, c_cur);
    x_nxt = total[W-1:0];
    c_nxt = total[W];
    y_nxt = perturb(x_cur, word);
  end

endmodule

// File: rtl/eac_pair_state.sv
// State registers: first register, second register and deferred carry.
module eac_pair_state
  import eac_pair_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned SEED_X = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  eac_cmd_e     cmd,
  input  logic [W-1:0] x_nxt,
  input  logic [W-1:0] y_nxt,
  input  logic         c_nxt,
  output logic [W-1:0] x_q,
  output logic [W-1:0] y_q,
  output logic         c_q
);

  localparam logic [W-1:0] X_INIT = W'(SEED_X);
  localparam logic [W-1:0] Y_INIT = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= X_INIT;
      y_q <= Y_INIT;
      c_q <= 1'b0;
    end else begin
      unique case (cmd)
        CMD_SEED: begin
          x_q <= X_INIT;
          y_q <= Y_INIT;
          c_q <= 1'b0;
        end
        CMD_ABSORB: begin
          x_q <= x_nxt;
          y_q <= y_nxt;
          c_q <= c_nxt;
        end
        default: begin
          x_q <= x_q;
          y_q <= y_q;
          c_q <= c_q;
        end
      endcase
    end
  end

endmodule

// File: rtl/eac_pair_ctrl.sv
// Handshake and result sequencing.
module eac_pair_ctrl
  import eac_pair_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clear,
  input  logic     in_valid,
  input  logic     in_last,
  output logic     in_ready,
  output logic     word_fire,
  output logic     show_q,
  output eac_cmd_e cmd
);

  always_comb begin
    in_ready  = !show_q && !clear;
    word_fire = in_valid && in_ready;
    if (clear || show_q)  cmd = CMD_SEED;
    else if (word_fire)   cmd = CMD_ABSORB;
    else                  cmd = CMD_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) show_q <= 1'b0;
    else        show_q <= word_fire && in_last;
  end

endmodule

// File: rtl/eac_pair_checksum.sv
module eac_pair_checksum
  import eac_pair_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned SEED_X = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           in_last,
  input  logic [W-1:0]   in_data,
  output logic           sum_valid,
  output logic [2*W-1:0] sum_out
);

  localparam int unsigned SUM_W = 2 * W;

  eac_cmd_e     cmd;
  logic         word_fire;
  logic         show_q;
  logic [W-1:0] x_q, y_q, x_nxt, y_nxt;
  logic         carry_q, c_nxt;

  eac_pair_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .word_fire (word_fire),
    .show_q    (show_q),
    .cmd       (cmd)
  );

  eac_pair_step #(.W(W)) u_step (
    .x_cur (x_q),
    .y_cur (y_q),
    .c_cur (carry_q),
    .word  (in_data),
    .x_nxt (x_nxt),
    .y_nxt (y_nxt),
    .c_nxt (c_nxt)
  );

  eac_pair_state #(.W(W), .SEED_X(SEED_X)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd),
    .x_nxt (x_nxt),
    .y_nxt (y_nxt),
    .c_nxt (c_nxt),
    .x_q   (x_q),
    .y_q   (y_q),
    .c_q   (carry_q)
  );

  logic [SUM_W-1:0] packed_sum;
  assign packed_sum = {x_q, y_q};
  assign sum_out    = packed_sum;
  assign sum_valid  = show_q;

endmodule

// File: rtl/eac_pair_checker.sv
module eac_pair_checker #(
  parameter int unsigned W      = 16,
  parameter int unsigned SEED_X = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clear,
  input logic           in_valid,
  input logic           in_ready,
  input logic           in_last,
  input logic [W-1:0]   in_data,
  input logic           sum_valid,
  input logic [2*W-1:0] sum_out,
  input logic           carry_q,
  input logic           word_fire
);

  localparam logic [2*W-1:0] SEED_WORD = {W'(SEED_X), {W{1'b0}}};

  logic [W:0] pre_sum;
  assign pre_sum = {1'b0, sum_out[2*W-1:W]} + {1'b0, sum_out[W-1:0]} + {{W{1'b0}}, carry_q};

  // R2: a clear drops ready and reloads the seed with zero carry
  a_r2_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !in_ready);
  a_r2_clear_seed: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sum_out == SEED_WORD) && !carry_q);

  // R3 and R5: first register and saved carry take the deferred-carry sum
  a_r3_sum_and_carry: assert property (@(posedge clk) disable iff (!rst_n)
    word_fire |=> {carry_q, sum_out[2*W-1:W]} == $past(pre_sum));

  // R4: second register becomes old first register XOR word
  a_r4_xor_update: assert property (@(posedge clk) disable iff (!rst_n)
    word_fire |=> sum_out[W-1:0] == $past(sum_out[2*W-1:W] ^ in_data));

  // R6: no accepted word and no clear keeps state
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_fire && !clear && !sum_valid) |=> $stable(sum_out) && $stable(carry_q));

  // R7: done pulse follows the last word and lasts one cycle
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> sum_valid);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |=> !sum_valid);
  a_r7_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |-> !in_ready);

  // R9: automatic return to the seed after the result cycle
  a_r9_reseed: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |=> (sum_out == SEED_WORD) && !carry_q);

endmodule

bind eac_pair_checksum eac_pair_checker #(.W(W), .SEED_X(SEED_X)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clear     (clear),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .in_data   (in_data),
  .sum_valid (sum_valid),
  .sum_out   (sum_out),
  .carry_q   (carry_q),
  .word_fire (word_fire)
);

// File: tb/tb_eac_pair_checksum.sv
`timescale 1ns/1ps
module tb_eac_pair_checksum;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready;
  logic        sum_valid;
  logic [31:0] sum_out;

  always #2.5 clk = ~clk;

  eac_pair_checksum dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .in_data   (in_data),
    .sum_valid (sum_valid),
    .sum_out   (sum_out)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Behavioural model of the recurrence
  int unsigned mx = 1, my = 0, mc = 0;
  bit mshow = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; runs one clock and compares on return (next negedge)
  task automatic cyc(input bit clr, input bit v, input bit l, input logic [15:0] d);
    bit rdy, fire;
    int unsigned t;
    clear = clr; in_valid = v; in_last = l; in_data = d;
    #1;
    rdy  = !mshow && !clr;
    fire = v && rdy;
    chk("R7/R2 in_ready", {31'b0, in_ready}, {31'b0, rdy});
    @(posedge clk);
    if (clr || mshow) begin
      mx = 1; my = 0; mc = 0;
    end else if (fire) begin
      t  = mc + mx + my;
      my = mx ^ d;
      mx = t % 65536;
      mc = t / 65536;
    end
    mshow = fire && l;
    @(negedge clk);
    chk("R3 first register", {16'b0, sum_out[31:16]}, mx);
    chk("R4 second register", {16'b0, sum_out[15:0]}, my);
    chk("R7 sum_valid", {31'b0, sum_valid}, {31'b0, mshow});
  endtask

  task automatic stream(input int len, input int kind, input int gap_pct);
    int n = 0;
    while (n < len) begin
      logic [15:0] w;
      bit v;
      w = (kind == 0) ? 16'h0000 : (kind == 1) ? 16'hFFFF : 16'($urandom);
      v = ($urandom % 100) >= gap_pct;
      cyc(0, v, (n == len - 1), w);
      if (v) n++;
    end
    // R8: result cycle shows both registers
    chk("R8 sum_valid at result", {31'b0, sum_valid}, 32'd1);
    cyc(0, 0, 0, 16'h0);
    // R9: back at seed
    chk("R9 reseed", sum_out, 32'h0001_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 sum_out after reset", sum_out, 32'h0001_0000);
    chk("R1 sum_valid after reset", {31'b0, sum_valid}, 32'd0);
    chk("R1 in_ready after reset", {31'b0, in_ready}, 32'd1);
    @(negedge clk);

    // R5: carry set by third word, consumed by the fourth
    cyc(0, 1, 0, 16'hFFFF);
    cyc(0, 1, 0, 16'hFFFF);
    cyc(0, 1, 0, 16'hFFFF);
    cyc(0, 1, 1, 16'h0000);
    chk("R5 deferred carry result", sum_out, 32'hFFFE_FFFD);
    chk("R8 done pulse", {31'b0, sum_valid}, 32'd1);
    cyc(0, 0, 0, 16'h0);
    chk("R9 seed after done", sum_out, 32'h0001_0000);

    // R6: stall keeps state
    cyc(0, 1, 0, 16'h1234);
    begin
      logic [31:0] held;
      held = sum_out;
      repeat (4) cyc(0, 0, 0, 16'hBEEF);
      chk("R6 state held while idle", sum_out, held);
    end

    // R2: clear with a word presented drops the word
    cyc(1, 1, 0, 16'h5A5A);
    chk("R2 seed after clear", sum_out, 32'h0001_0000);
    chk("R2 no done after clear", {31'b0, sum_valid}, 32'd0);
    // carry must be zero after clear: two words of all ones give known value
    cyc(0, 1, 0, 16'hFFFF);
    cyc(0, 1, 1, 16'hFFFF);
    chk("R2 carry cleared", sum_out, 32'hFFFF_FFFE);
    // clear during the result cycle
    cyc(1, 0, 0, 16'h0);
    chk("R2 clear in result cycle", sum_out, 32'h0001_0000);

    // Long all-zero and all-ones streams, then random streams with gaps
    stream(40, 0, 0);
    stream(300, 1, 0);
    stream(300, 1, 30);
    for (int s = 0; s < 40; s++) begin
      stream(1 + ($urandom % 60), 2, $urandom % 50);
      if (($urandom % 4) == 0) cyc(1, 1, 0, 16'($urandom));
    end
    // single-word stream
    stream(1, 2, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule